// File: doc/BRIEF.md
# Single-Channel Paced DMA Channel

This block is one DMA channel that copies data from a source address to a destination address with no processor involvement. Software programs four 32-bit registers: a source pointer, a destination pointer, a count of transfer cycles and a control word. It then sets the enable bit. On each beat the channel reads one item through a read port and writes the same data through a write port. After the write it moves each pointer up, down or not at all, as its step code selects. A beat may come back with a bus error, and the channel then stops.

The channel can be made to wait on peripheral request lines, one line for the source side and one for the destination side. It answers each paced cycle with a one-cycle grant pulse. Burst mode moves four beats for each request and multiplies every pointer step by four. When the count runs out, or when an error stops the channel, the enable bit clears and a sticky status bit is set. Each status bit drives an interrupt output through its own enable bit. Two plain valid/ready ports stand in for the buses. A side-select output on each port tells the bus fabric whether that access goes to the peripheral bus or to the memory bus.

Top module: `xfer_channel`

## Requirements
- R1: Register index 0 is the source pointer, 1 the destination pointer, 2 the cycle count and 3 the control word, and all four read back on regRdData. Only the low 24 bits of the count are kept. Control bits 11, 15, 23:22 and 31:28 always read as zero.
- R2: Writing the control word with bit 0 set while bit 0 is clear starts a transfer. While bit 0 is set, register writes change nothing except the status-clear action of R11.
- R3: Source step code bits 10:8 and destination step code bits 14:12 move the pointer after each beat. Codes 000 and 100 mean no change, 001/010/011 mean +1/+2/+4 and 101/110/111 mean -1/-2/-4.
- R4: With burst (bit 3) set, every step is four times as large and one cycle moves four beats. Without burst, one cycle moves one beat.
- R5: Each beat reads at the source pointer and then writes the data it read to the destination pointer. rdSide follows bit 6 and wrSide follows bit 7 (0 selects the peripheral bus, 1 the memory bus). Both size outputs follow bits 21:20 (00 word, 01 halfword, 10 byte).
- R6: Bits 27:24 select the source request line and bits 19:16 the destination request line. A nonzero line must be high before a cycle starts, and that line's dmaGrant bit pulses for one clock each time a cycle starts. Line 0 means the cycle does not wait.
- R7: When the count reaches zero, bit 0 clears and finish status (bit 1) is set. A start with a count of zero finishes with no beat.
- R8: An error response on a read or a write stops the channel at once. Bit 0 clears, error status (bit 4) is set, and the pointer and count updates for the failing beat do not happen.
- R9: A start with width code 11 ends in error status at once, with no beat.
- R10: irqDone is high while finish status and bit 2 are both set. irqErr is high while error status and bit 5 are both set.
- R11: Writing 0 to a status bit clears it, and writing 1 leaves it as it was. When the channel sets a status bit in the same cycle that software clears it, the bit stays set.
- R12: After reset all registers read zero and no valid, grant or interrupt output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index for write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the indexed register |
| dmaReq | input | 16 | Peripheral request lines (bit 0 unused) |
| dmaGrant | output | 16 | One-cycle grant pulses |
| rdValid | output | 1 | Read request valid |
| rdAddr | output | 32 | Read address |
| rdSide | output | 1 | Read bus select, 1 = memory bus |
| rdSize | output | 2 | Read width code |
| rdReady | input | 1 | Read accepted, data present |
| rdData | input | 32 | Read data |
| rdErr | input | 1 | Read error, qualified by rdReady |
| wrValid | output | 1 | Write request valid |
| wrAddr | output | 32 | Write address |
| wrSide | output | 1 | Write bus select, 1 = memory bus |
| wrSize | output | 2 | Write width code |
| wrData | output | 32 | Write data |
| wrReady | input | 1 | Write accepted |
| wrErr | input | 1 | Write error, qualified by wrReady |
| irqDone | output | 1 | Finish interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
Two events can fall on the same clock edge: software clears the finish status bit, and the channel completes a zero-count transfer and sets that same bit. The bench starts a zero-count transfer and counts the register pipeline by hand, so that it knows the edge on which the finish fires. It drives a clearing write of the control word onto exactly that edge. Afterwards it expects finish status still set and enable clear. A separate idle write then shows that the clear works when nothing collides with it.

// File: rtl/xfer_pkg.sv
`timescale 1ns/1ps
package xfer_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic grant;   // a paced cycle starts this clock
    logic latch;   // capture read data
    logic step;    // advance both pointers
    logic dec;     // one cycle completed
    logic finish;  // count exhausted
    logic fail;    // error stop
  } xfer_strobe_t;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int EN_BIT       = 0;
  localparam int FIN_BIT      = 1;
  localparam int FIN_EN_BIT   = 2;
  localparam int BURST_BIT    = 3;
  localparam int ERR_BIT      = 4;
  localparam int ERR_EN_BIT   = 5;
  localparam int SRC_SIDE_BIT = 6;
  localparam int DST_SIDE_BIT = 7;
  localparam int SRC_STEP_LSB = 8;
  localparam int DST_STEP_LSB = 12;
  localparam int DST_LINE_LSB = 16;
  localparam int WIDTH_LSB    = 20;
  localparam int SRC_LINE_LSB = 24;
  localparam logic [31:0] CTRL_MASK = 32'h0F3F_77FF;

  // Signed pointer increment for a three-bit step code
  function automatic logic [31:0] stepOf(input logic [2:0] code, input logic burstOn);
    logic [31:0] mag;
    unique case (code[1:0])
      2'd0:    mag = 32'd0;
      2'd1:    mag = 32'd1;
      2'd2:    mag = 32'd2;
      default: mag = 32'd4;
    endcase
    if (burstOn) mag = mag << 2;
    return code[2] ? (~mag + 32'd1) : mag;
  endfunction

endpackage

// File: rtl/xfer_ctrl.sv
`timescale 1ns/1ps
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int BURST_BEATS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         burst,
  input  logic         widthBad,
  input  logic         cntZero,
  input  logic         reqOk,
  input  logic         rdReady,
  input  logic         rdErr,
  input  logic         wrReady,
  input  logic         wrErr,
  output logic         rdValid,
  output logic         wrValid,
  output xfer_strobe_t strobe
);
  localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BURST = BEAT_W'(BURST_BEATS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_READ, S_WRITE} state_t;

  state_t state, stateNext;
  logic [BEAT_W-1:0] beat, beatNext;
  logic lastBeat;

  assign lastBeat = burst ? (beat == LAST_BURST) : 1'b1;

  always_comb begin
    stateNext = state;
    beatNext  = beat;
    strobe    = '0;
    rdValid   = 1'b0;
    wrValid   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (enable) begin
          if (widthBad) strobe.fail = 1'b1;
          else          stateNext   = S_WAIT;
        end
      end
      S_WAIT: begin
        if (cntZero) begin
          strobe.finish = 1'b1;
          stateNext     = S_IDLE;
        end else if (reqOk) begin
          strobe.grant = 1'b1;
          beatNext     = '0;
          stateNext    = S_READ;
        end
      end
      S_READ: begin
        rdValid = 1'b1;
        if (rdReady) begin
          if (rdErr) begin
            strobe.fail = 1'b1;
            stateNext   = S_IDLE;
          end else begin
            strobe.latch = 1'b1;
            stateNext    = S_WRITE;
          end
        end
      end
      default: begin
        wrValid = 1'b1;
        if (wrReady) begin
          if (wrErr) begin
            strobe.fail = 1'b1;
            stateNext   = S_IDLE;
          end else begin
            strobe.step = 1'b1;
            if (lastBeat) begin
              strobe.dec = 1'b1;
              stateNext  = S_WAIT;
            end else begin
              beatNext  = beat + 1'b1;
              stateNext = S_READ;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      beat  <= '0;
    end else begin
      state <= stateNext;
      beat  <= beatNext;
    end
  end

  // R5
  one_side_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrValid));

  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdReady) |=> rdValid);

  // R8
  term_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.finish && strobe.fail));

  // R2
  no_idle_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !(rdValid || wrValid));

endmodule

// File: rtl/xfer_dp.sv
`timescale 1ns/1ps
module xfer_dp
  import xfer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 24,
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  xfer_strobe_t         strobe,
  input  logic [31:0]          rdData,
  input  logic [NUM_LINES-1:0] dmaReq,
  output logic [NUM_LINES-1:0] dmaGrant,
  output logic [ADDR_W-1:0]    srcAddr,
  output logic [ADDR_W-1:0]    dstAddr,
  output logic [31:0]          dataOut,
  output logic                 enable,
  output logic                 burst,
  output logic                 widthBad,
  output logic                 cntZero,
  output logic                 reqOk,
  output logic                 srcSide,
  output logic                 dstSide,
  output logic [1:0]           xferSize,
  output logic                 irqDone,
  output logic                 irqErr
);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [31:0]       ctrlReg, ctrlNext;
  logic [CNT_W-1:0]  cnt;
  logic [LINE_W-1:0] srcLine, dstLine;
  logic [31:0]       srcStep, dstStep;
  logic              idleWr;

  assign enable   = ctrlReg[EN_BIT];
  assign burst    = ctrlReg[BURST_BIT];
  assign srcSide  = ctrlReg[SRC_SIDE_BIT];
  assign dstSide  = ctrlReg[DST_SIDE_BIT];
  assign xferSize = ctrlReg[WIDTH_LSB +: 2];
  assign widthBad = (xferSize == 2'b11);
  assign cntZero  = (cnt == '0);
  assign srcLine  = ctrlReg[SRC_LINE_LSB +: LINE_W];
  assign dstLine  = ctrlReg[DST_LINE_LSB +: LINE_W];
  assign reqOk    = ((srcLine == '0) || dmaReq[srcLine]) &&
                    ((dstLine == '0) || dmaReq[dstLine]);
  assign irqDone  = ctrlReg[FIN_BIT] && ctrlReg[FIN_EN_BIT];
  assign irqErr   = ctrlReg[ERR_BIT] && ctrlReg[ERR_EN_BIT];
  assign srcStep  = stepOf(ctrlReg[SRC_STEP_LSB +: 3], burst);
  assign dstStep  = stepOf(ctrlReg[DST_STEP_LSB +: 3], burst);
  assign idleWr   = regWrEn && !enable;

  // Grant pulses on each selected nonzero line
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_grant
    if (i == 0) begin : g_none
      assign dmaGrant[i] = 1'b0;
    end else begin : g_line
      assign dmaGrant[i] = strobe.grant &&
                           ((srcLine == LINE_W'(i)) || (dstLine == LINE_W'(i)));
    end
  end

  // Control word: software update first, hardware events override
  always_comb begin
    ctrlNext = ctrlReg;
    if (regWrEn && regAddr == REG_CTRL) begin
      if (!enable) ctrlNext = regWrData & CTRL_MASK;
      ctrlNext[FIN_BIT] = ctrlReg[FIN_BIT] & regWrData[FIN_BIT];
      ctrlNext[ERR_BIT] = ctrlReg[ERR_BIT] & regWrData[ERR_BIT];
    end
    if (strobe.finish) begin
      ctrlNext[EN_BIT]  = 1'b0;
      ctrlNext[FIN_BIT] = 1'b1;
    end
    if (strobe.fail) begin
      ctrlNext[EN_BIT]  = 1'b0;
      ctrlNext[ERR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      srcAddr <= '0;
      dstAddr <= '0;
      cnt     <= '0;
      dataOut <= '0;
    end else begin
      ctrlReg <= ctrlNext;
      if (idleWr && regAddr == REG_SRC) srcAddr <= regWrData[ADDR_W-1:0];
      if (idleWr && regAddr == REG_DST) dstAddr <= regWrData[ADDR_W-1:0];
      if (idleWr && regAddr == REG_CNT) cnt     <= regWrData[CNT_W-1:0];
      if (strobe.step) begin
        srcAddr <= srcAddr + srcStep[ADDR_W-1:0];
        dstAddr <= dstAddr + dstStep[ADDR_W-1:0];
      end
      if (strobe.dec)   cnt     <= cnt - 1'b1;
      if (strobe.latch) dataOut <= rdData;
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_SRC: regRdData = 32'(srcAddr);
      REG_DST: regRdData = 32'(dstAddr);
      REG_CNT: regRdData = 32'(cnt);
      default: regRdData = ctrlReg;
    endcase
  end

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> !cntZero);

  // R8
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> (ctrlReg[FIN_BIT] || ctrlReg[ERR_BIT]));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && enable && !$past(strobe.step)) |-> $stable(srcAddr));

  // R6
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (dmaGrant == '0));

endmodule

// File: rtl/xfer_channel.sv
`timescale 1ns/1ps
module xfer_channel
  import xfer_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int NUM_LINES   = 16,
  parameter int BURST_BEATS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] dmaReq,
  output logic [NUM_LINES-1:0] dmaGrant,
  output logic                 rdValid,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic                 rdSide,
  output logic [1:0]           rdSize,
  input  logic                 rdReady,
  input  logic [31:0]          rdData,
  input  logic                 rdErr,
  output logic                 wrValid,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic                 wrSide,
  output logic [1:0]           wrSize,
  output logic [31:0]          wrData,
  input  logic                 wrReady,
  input  logic                 wrErr,
  output logic                 irqDone,
  output logic                 irqErr
);
  xfer_strobe_t strobe;
  logic enable, burst, widthBad, cntZero, reqOk;
  logic [1:0] xferSize;

  xfer_ctrl #(.BURST_BEATS(BURST_BEATS)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .burst(burst), .widthBad(widthBad),
    .cntZero(cntZero), .reqOk(reqOk), .rdReady(rdReady), .rdErr(rdErr),
    .wrReady(wrReady), .wrErr(wrErr), .rdValid(rdValid), .wrValid(wrValid),
    .strobe(strobe)
  );

  xfer_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .rdData(rdData), .dmaReq(dmaReq), .dmaGrant(dmaGrant),
    .srcAddr(rdAddr), .dstAddr(wrAddr), .dataOut(wrData),
    .enable(enable), .burst(burst), .widthBad(widthBad), .cntZero(cntZero),
    .reqOk(reqOk), .srcSide(rdSide), .dstSide(wrSide), .xferSize(xferSize),
    .irqDone(irqDone), .irqErr(irqErr)
  );

  assign rdSize = xferSize;
  assign wrSize = xferSize;

endmodule

// File: tb/sim_xfer_channel.sv
`timescale 1ns/1ps
module sim_xfer_channel;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, regWrEn;
  logic [1:0] regAddr;
  logic [31:0] regWrData, regRdData;
  logic [15:0] dmaReq, dmaGrant;
  logic rdValid, rdSide, rdReady, rdErr, wrValid, wrSide, wrReady, wrErr;
  logic [31:0] rdAddr, rdData, wrAddr, wrData;
  logic [1:0] rdSize, wrSize;
  logic irqDone, irqErr;

  xfer_channel u0 (.*);

  int total = 0, bad = 0;
  logic [31:0] cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Memory model
  logic stallOn = 0, rdErrArm = 0, wrErrArm = 0;
  logic [31:0] rdErrAddr = 0, wrErrAddr = 0;
  assign rdReady = stallOn ? cyc[0] : 1'b1;
  assign wrReady = stallOn ? ~cyc[1] : 1'b1;
  assign rdData  = rdAddr ^ 32'h5A5A_0000;
  assign rdErr   = rdErrArm && (rdAddr == rdErrAddr);
  assign wrErr   = wrErrArm && (wrAddr == wrErrAddr);

  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic        logSide [64];
  logic        logRdSide [64];
  logic [1:0]  logSize [64];
  int nWr = 0, nRd = 0;
  int grantCnt [16];

  always @(negedge clk) begin
    if (wrValid && wrReady) begin
      if (nWr < 64) begin
        logAddr[nWr] = wrAddr; logData[nWr] = wrData;
        logSide[nWr] = wrSide; logSize[nWr] = wrSize;
      end
      nWr++;
    end
    if (rdValid && rdReady) begin
      if (nRd < 64) logRdSide[nRd] = rdSide;
      nRd++;
    end
    for (int i = 0; i < 16; i++) if (dmaGrant[i]) grantCnt[i]++;
  end

  always @(posedge clk) if (cyc > 150000) begin
    bad++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  task automatic clearLogs();
    nWr = 0; nRd = 0;
    for (int i = 0; i < 16; i++) grantCnt[i] = 0;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    int n = 0;
    regRead(2'd3, v);
    while (v[0] && n < 3000) begin
      @(negedge clk); regRead(2'd3, v); n++;
    end
    chk(!v[0], req, v, 32'h0);
  endtask

  task automatic startXfer(input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] c, input logic [31:0] ctl);
    regWrite(2'd3, 32'h0);
    regWrite(2'd0, s); regWrite(2'd1, d); regWrite(2'd2, c);
    clearLogs();
    regWrite(2'd3, ctl | 32'h1);
  endtask

  function automatic logic [31:0] expStep(input logic [2:0] code, input logic b);
    logic [31:0] m;
    case (code)
      3'd1: m = 1;  3'd2: m = 2;  3'd3: m = 4;
      3'd5: m = -1; 3'd6: m = -2; 3'd7: m = -4;
      default: m = 0;
    endcase
    return b ? m * 4 : m;
  endfunction

  // src, dst, cycles, control (enable added by the bench)
  localparam logic [127:0] VEC [6] = '{
    {32'h0000_1000, 32'h0000_2000, 32'd3, 32'h0000_1144},
    {32'h0001_0000, 32'h0002_0000, 32'd2, 32'h0020_0388},
    {32'h0000_0100, 32'h0000_0200, 32'd4, 32'h0010_6504},
    {32'h0000_8000, 32'h0000_9000, 32'd1, 32'h0000_27C8},
    {32'h0000_0400, 32'h0000_0500, 32'd2, 32'h0000_44C0},
    {32'h0000_0700, 32'h0000_0800, 32'd5, 32'h0000_3004}
  };

  initial begin
    logic [31:0] v, s, d, c, ctl, ss, ds;
    int n;
    rstN = 0; regWrEn = 0; regAddr = 0; regWrData = 0; dmaReq = 0;
    for (int i = 0; i < 16; i++) grantCnt[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 4; a++) begin
      regRead(2'(a), v); chk(v == 0, "R12", v, 0);
    end
    chk(!rdValid && !wrValid && dmaGrant == 0 && !irqDone && !irqErr, "R12",
        {rdValid, wrValid, irqDone, irqErr}, 0);

    // R1 reserved bits and count width
    regWrite(2'd3, 32'hFFFF_FFFE); regRead(2'd3, v);
    chk(v == 32'h0F3F_77EC, "R1", v, 32'h0F3F_77EC);
    regWrite(2'd3, 32'h0);
    regWrite(2'd2, 32'hFFFF_FFFF); regRead(2'd2, v);
    chk(v == 32'h00FF_FFFF, "R1", v, 32'h00FF_FFFF);

    // Vector table: R3 R4 R5 R7 R10
    for (int r = 0; r < 6; r++) begin
      s = VEC[r][127:96]; d = VEC[r][95:64]; c = VEC[r][63:32]; ctl = VEC[r][31:0];
      stallOn = r[0];
      startXfer(s, d, c, ctl);
      waitIdle("R7");
      n = int'(c) * (ctl[3] ? 4 : 1);
      ss = expStep(ctl[10:8], ctl[3]); ds = expStep(ctl[14:12], ctl[3]);
      chk(nWr == n, ctl[3] ? "R4" : "R7", nWr, n);
      for (int i = 0; i < n && i < 64; i++) begin
        chk(logAddr[i] == d + 32'(i) * ds, "R3", logAddr[i], d + 32'(i) * ds);
        chk(logData[i] == ((s + 32'(i) * ss) ^ 32'h5A5A_0000), "R5", logData[i],
            (s + 32'(i) * ss) ^ 32'h5A5A_0000);
        chk(logSide[i] == ctl[7] && logRdSide[i] == ctl[6], "R5",
            {logSide[i], logRdSide[i]}, {ctl[7], ctl[6]});
        chk(logSize[i] == ctl[21:20], "R5", logSize[i], ctl[21:20]);
      end
      regRead(2'd0, v); chk(v == s + 32'(n) * ss, "R3", v, s + 32'(n) * ss);
      regRead(2'd1, v); chk(v == d + 32'(n) * ds, "R3", v, d + 32'(n) * ds);
      regRead(2'd2, v); chk(v == 0, "R7", v, 0);
      regRead(2'd3, v); chk(v[1] && !v[4], "R7", v, ctl | 32'h2);
      chk(irqDone == ctl[2], "R10", irqDone, ctl[2]);
    end
    stallOn = 0;

    // R11 collision: finish set on the same edge as a clearing write
    regWrite(2'd2, 32'h0);
    regWrite(2'd3, 32'h0000_0007);
    regWrite(2'd3, 32'h0);
    @(negedge clk); regRead(2'd3, v);
    chk(v[1] && !v[0], "R11", v, 32'h6);
    regWrite(2'd3, 32'h4); regRead(2'd3, v);
    chk(!v[1] && !irqDone, "R11", v, 32'h4);
    regWrite(2'd3, 32'h2); regRead(2'd3, v);
    chk(!v[1], "R11", v, 32'h0);

    // R7 zero count start
    startXfer(32'h10, 32'h20, 32'h0, 32'h4);
    waitIdle("R7"); regRead(2'd3, v);
    chk(nWr == 0 && v[1] && irqDone, "R7", {nWr[15:0], v[15:0]}, 32'h6);

    // R6 pacing, R2 busy writes ignored
    startXfer(32'h5000, 32'h6000, 32'd2, 32'h0509_1100);
    repeat (20) @(negedge clk);
    chk(nRd == 0 && nWr == 0, "R6", nRd, 0);
    regWrite(2'd0, 32'hDEAD_0000); regRead(2'd0, v);
    chk(v == 32'h5000, "R2", v, 32'h5000);
    regWrite(2'd3, 32'h0000_0009); regRead(2'd3, v);
    chk(v == 32'h0509_1101, "R2", v, 32'h0509_1101);
    @(posedge clk); #1; dmaReq[5] = 1'b1;
    repeat (10) @(negedge clk);
    chk(nRd == 0, "R6", nRd, 0);
    @(posedge clk); #1; dmaReq[9] = 1'b1;
    waitIdle("R6");
    chk(nWr == 2 && grantCnt[5] == 2 && grantCnt[9] == 2, "R6",
        {nWr[7:0], grantCnt[5][7:0], grantCnt[9][7:0]}, 32'h020202);
    chk(grantCnt[1] == 0 && grantCnt[0] == 0, "R6", grantCnt[1], 0);
    dmaReq = 0;

    // R8 read error
    rdErrArm = 1; rdErrAddr = 32'h3002;
    startXfer(32'h3000, 32'h4000, 32'd5, 32'h0000_1120);
    waitIdle("R8"); rdErrArm = 0;
    regRead(2'd3, v); chk(v[4] && !v[1] && irqErr, "R8", v, 32'h30);
    chk(nWr == 2, "R8", nWr, 2);
    regRead(2'd0, v); chk(v == 32'h3002, "R8", v, 32'h3002);
    regRead(2'd2, v); chk(v == 3, "R8", v, 3);

    // R8 write error
    wrErrArm = 1; wrErrAddr = 32'h4001;
    startXfer(32'h3000, 32'h4000, 32'd5, 32'h0000_1100);
    waitIdle("R8"); wrErrArm = 0;
    regRead(2'd3, v); chk(v[4] && !irqErr, "R10", v, 32'h10);
    regRead(2'd1, v); chk(v == 32'h4001, "R8", v, 32'h4001);
    regRead(2'd2, v); chk(v == 4, "R8", v, 4);

    // R9 illegal width
    startXfer(32'h0, 32'h0, 32'd3, 32'h0030_0020);
    waitIdle("R9");
    regRead(2'd3, v); chk(v[4] && irqErr && nRd == 0, "R9", v, 32'h0030_0030);
    regRead(2'd2, v); chk(v == 3, "R9", v, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule